// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave side of a serial control port that reaches a bank of byte-wide registers. A host selects the port with an active-low chip select and sends clock pulses. It moves data on one shared bidirectional line. A second line, used only for output, is also available. Each transfer is sixteen bits long and sent most significant bit first. Seven address bits come first, then one direction bit, then eight data bits. When the direction bit is 1 the data byte is written to the addressed register. When it is 0 the addressed register is returned to the host.

The register bank is outside the block. The port shows the address as soon as the seventh bit has arrived. It issues a one-cycle write strobe with the data byte. It takes the read byte from a combinational read-data input. The bank also supplies a routing bit, `so_mode`. When this bit is 0, read data goes back on the shared line after a turnaround. When it is 1, read data goes out on the separate output line and the shared line is never driven.

The serial clock, chip select and data input are asynchronous to the system clock. Each passes through a synchronizer and is sampled by the system clock. Serial clock edges are detected from the sampled copy.

Top module: `tri_wire_regport`

## Requirements
- R1: Bits are sampled on rising serial-clock edges, most significant bit first. The fields are, in order: address bits 6 down to 0, the direction bit, then data bits 7 down to 0. A direction bit of 1 makes `reg_wr` write the data byte to `reg_addr`.
- R2: A complete write frame produces exactly one single-cycle `reg_wr` pulse, after the 16th rising edge. Rising edges after the 16th within the same selection have no effect.
- R3: A write frame cut short by `cs_n` going high before the 16th rising edge produces no `reg_wr` pulse, and the register keeps its value.
- R4: With `so_mode` = 0, a read frame (direction bit 0) returns the register byte on `sio_out`, most significant bit first. Each bit is launched from the falling edge that follows rising edges 8 through 15. `sio_oe` stays high for the whole data phase and `so_oe` stays low. The host never has to drive the shared line while the block drives it.
- R5: With `so_mode` = 1, a read frame returns the byte on `so_out`. Bits are launched from rising edges 8 through 15. `so_oe` is high during the data phase and `sio_oe` stays low for the whole frame.
- R6: Both output enables are low during the address and direction bits, in write frames, after the falling edge that follows the 16th rising edge, and within a few system cycles of `cs_n` going high, including in the middle of a read.
- R7: Raising `cs_n` clears the bit counter, so the next frame is decoded from its first bit even after an aborted one.
- R8: After reset both output enables and `reg_wr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sck | input | 1 | Serial clock from the host |
| sio_in | input | 1 | Shared data line as seen at the pin |
| sio_out | output | 1 | Value driven onto the shared data line |
| sio_oe | output | 1 | Drive enable for the shared data line |
| so_out | output | 1 | Value on the separate output line |
| so_oe | output | 1 | Drive enable for the separate output line |
| so_mode | input | 1 | Read routing from the register bank: 0 shared line, 1 separate line |
| reg_addr | output | 7 | Register address of the current frame |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Byte to write |
| reg_rdata | input | 8 | Byte read from the addressed register |

## Verification
The hardest case to reach is an abort in the middle of a read on the shared line, after the block has taken the line over and before the turnaround at the end. The bench gets there by letting a shared-line read run ten bits and then raising the select. It checks that the line is released. It then runs a fresh frame to show the counter restarted. An early abort inside the address field, followed by a full write, covers the same path without any driver enabled.

// File: rtl/trw_pkg.sv
package trw_pkg;

    // How read data leaves the block
    typedef enum logic {
        DRV_SHARED   = 1'b0,
        DRV_SEPARATE = 1'b1
    } drv_route_e;

    localparam int unsigned DEF_ADDR_W  = 7;
    localparam int unsigned DEF_DATA_W  = 8;
    localparam int unsigned DEF_SYNC_ST = 2;

endpackage

// File: rtl/trw_sync.sv
module trw_sync #(
    parameter int unsigned   W       = 1,
    parameter int unsigned   STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            stg_d[k] = stg_q[k-1];
        end
    end

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[k] <= RST_VAL;
            else        stg_q[k] <= stg_d[k];
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/trw_edge.sv
module trw_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

endmodule

// File: rtl/trw_frame.sv
module trw_frame
    import trw_pkg::*;
#(
    parameter int unsigned AW = DEF_ADDR_W,
    parameter int unsigned DW = DEF_DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_act,
    input  logic          sck_rise,
    input  logic          sck_fall,
    input  logic          sdi,
    input  logic          so_mode,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] addr,
    output logic          wr,
    output logic [DW-1:0] wdata,
    output logic          bit_o,
    output logic          oe,
    output drv_route_e    route
);

    localparam int unsigned NB  = AW + 1 + DW;
    localparam int unsigned CW  = $clog2(NB + 1);
    localparam int unsigned SHW = ((AW > DW) ? AW : DW) - 1;
    localparam logic [CW-1:0] C_ADDR_LAST = CW'(AW - 1);
    localparam logic [CW-1:0] C_DIR       = CW'(AW);
    localparam logic [CW-1:0] C_LAST      = CW'(NB - 1);
    localparam logic [CW-1:0] C_DONE      = CW'(NB);

    typedef struct packed {
        logic [CW-1:0]  cnt;
        logic [SHW-1:0] sh;
        logic [AW-1:0]  addr;
        logic           dir;
        logic           rd;
        drv_route_e     route;
        logic [DW-1:0]  tx;
        logic           bit_o;
        logic           oe;
        logic           wr;
        logic [DW-1:0]  wdata;
    } st_t;

    st_t q, n;

    always_comb begin
        n    = q;
        n.wr = 1'b0;
        if (!cs_act) begin
            n.cnt = '0;
            n.rd  = 1'b0;
            n.oe  = 1'b0;
        end else begin
            if (sck_rise && q.cnt != C_DONE) begin
                n.cnt = q.cnt + 1'b1;
                n.sh  = {q.sh[SHW-2:0], sdi};
                if (q.cnt == C_ADDR_LAST) begin
                    n.addr = {q.sh[AW-2:0], sdi};
                end
                if (q.cnt == C_DIR) begin
                    n.dir   = sdi;
                    n.route = drv_route_e'(so_mode);
                    if (!sdi) begin
                        n.rd = 1'b1;
                        n.tx = rdata;
                        if (so_mode) begin
                            n.bit_o = rdata[DW-1];
                            n.tx    = rdata << 1;
                            n.oe    = 1'b1;
                        end
                    end
                end
                if (q.rd && q.route == DRV_SEPARATE &&
                    q.cnt > C_DIR && q.cnt < C_LAST) begin
                    n.bit_o = q.tx[DW-1];
                    n.tx    = q.tx << 1;
                    n.oe    = 1'b1;
                end
                if (q.cnt == C_LAST && q.dir) begin
                    n.wr    = 1'b1;
                    n.wdata = {q.sh[DW-2:0], sdi};
                end
            end
            if (sck_fall && q.rd) begin
                if (q.route == DRV_SHARED && q.cnt > C_DIR && q.cnt < C_DONE) begin
                    n.bit_o = q.tx[DW-1];
                    n.tx    = q.tx << 1;
                    n.oe    = 1'b1;
                end
                if (q.cnt == C_DONE) begin
                    n.oe = 1'b0;
                    n.rd = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.route <= DRV_SHARED;
        end else begin
            q <= n;
        end
    end

    assign addr  = q.addr;
    assign wr    = q.wr;
    assign wdata = q.wdata;
    assign bit_o = q.bit_o;
    assign oe    = q.oe;
    assign route = q.route;

    AST_WR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr |=> !q.wr);                                                  // R2
    AST_WR_FULL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr |-> (q.cnt == C_DONE && q.dir));                             // R3
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (q.cnt == '0 && !q.oe && !q.rd));                     // R7
    AST_OE_IN_DATA_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        q.oe |-> (q.rd && !q.dir && q.cnt > C_DIR));                      // R6
    AST_OUT_HELD_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.oe && cs_act && !sck_rise && !sck_fall) |=> $stable(q.bit_o)); // R4

endmodule

// File: rtl/tri_wire_regport.sv
module tri_wire_regport
    import trw_pkg::*;
#(
    parameter int unsigned ADDR_W  = DEF_ADDR_W,
    parameter int unsigned DATA_W  = DEF_DATA_W,
    parameter int unsigned SYNC_ST = DEF_SYNC_ST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              sio_in,
    output logic              sio_out,
    output logic              sio_oe,
    output logic              so_out,
    output logic              so_oe,
    input  logic              so_mode,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);

    localparam int unsigned NSIG = 3;

    logic [NSIG-1:0] pin_raw, pin_s;
    logic            sck_rise, sck_fall;
    logic            bit_o, oe;
    drv_route_e      route;

    assign pin_raw = {cs_n, sck, sio_in};

    trw_sync #(
        .W       (NSIG),
        .STAGES  (SYNC_ST),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_raw),
        .dout  (pin_s)
    );

    trw_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (pin_s[1]),
        .rise  (sck_rise),
        .fall  (sck_fall)
    );

    trw_frame #(
        .AW (ADDR_W),
        .DW (DATA_W)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_act   (~pin_s[2]),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .sdi      (pin_s[0]),
        .so_mode  (so_mode),
        .rdata    (reg_rdata),
        .addr     (reg_addr),
        .wr       (reg_wr),
        .wdata    (reg_wdata),
        .bit_o    (bit_o),
        .oe       (oe),
        .route    (route)
    );

    assign sio_out = bit_o;
    assign so_out  = bit_o;
    assign sio_oe  = oe & (route == DRV_SHARED);
    assign so_oe   = oe & (route == DRV_SEPARATE);

endmodule

// File: tb/sim_tri_wire_regport.sv
`timescale 1ns/1ps
module sim_tri_wire_regport;

    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       drv_en = 1'b0;
    logic       drv_val = 1'b1;
    logic       sio_line, sio_out, sio_oe, so_out, so_oe, so_mode, reg_wr;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [7:0] mem [128];
    int         n_chk = 0;
    int         n_err = 0;
    int         wr_cnt = 0;
    int         clash = 0;

    always #2.5 clk = ~clk;

    assign sio_line  = sio_oe ? sio_out : (drv_en ? drv_val : 1'b1);
    assign reg_rdata = mem[reg_addr];
    assign so_mode   = mem[7'h14][0];

    tri_wire_regport u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sio_in(sio_line),
        .sio_out(sio_out), .sio_oe(sio_oe), .so_out(so_out), .so_oe(so_oe),
        .so_mode(so_mode), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 8'(i) ^ 8'h5A;
    end

    always @(posedge clk) begin
        if (reg_wr) begin
            mem[reg_addr] <= reg_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    always @(negedge clk) if (sio_oe && drv_en) clash <= clash + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drives one frame of nbits; leaves cs_n high at the end
    task automatic run_frame(input logic [6:0] a, input logic dir, input logic [7:0] wd,
                             input int nbits, output logic [7:0] rb, output int oe_bad);
        logic mode;
        logic bv;
        mode   = so_mode;
        rb     = '0;
        oe_bad = 0;
        @(negedge clk);
        cs_n = 1'b0;
        idle(HALF);
        for (int i = 0; i < nbits; i++) begin
            bv = (i < 7) ? a[6-i] : (i == 7) ? dir : (i < 16) ? wd[15-i] : 1'b0;
            if (i < 8 || dir) begin
                drv_en = 1'b1; drv_val = bv;
            end else begin
                drv_en = 1'b0;
            end
            idle(HALF);
            if ((i < 8 || dir) && (sio_oe || so_oe)) oe_bad++;
            if (!dir && !mode && i >= 8 && i < 16) begin
                rb[15-i] = sio_line;
                if (!sio_oe || so_oe) oe_bad++;
            end
            sck = 1'b1;
            idle(HALF);
            if (dir && (sio_oe || so_oe)) oe_bad++;
            if (!dir && mode && i >= 7 && i < 15) begin
                rb[14-i] = so_out;
                if (!so_oe || sio_oe) oe_bad++;
            end
            sck = 1'b0;
        end
        drv_en = 1'b0;
        idle(HALF);
        if (nbits >= 16 && (sio_oe || so_oe)) oe_bad++;
        cs_n = 1'b1;
        idle(HALF);
        if (sio_oe || so_oe) oe_bad++;
    endtask

    task automatic t_reset;
        chk(!sio_oe && !so_oe && !reg_wr, "R8 reset outputs",
            {sio_oe, so_oe, reg_wr}, 0);
    endtask

    task automatic t_write(input logic [6:0] a, input logic [7:0] d);
        logic [7:0] rb; int bad; int w0;
        w0 = wr_cnt;
        run_frame(a, 1'b1, d, 16, rb, bad);
        chk(wr_cnt == w0 + 1, "R2 one strobe per write", wr_cnt - w0, 1);
        chk(mem[a] == d, "R1 written byte", mem[a], d);
        chk(bad == 0, "R6 enables low in write", bad, 0);
    endtask

    task automatic t_read(input logic [6:0] a, input string req);
        logic [7:0] rb; int bad; logic [7:0] exp;
        exp = mem[a];
        run_frame(a, 1'b0, 8'h00, 16, rb, bad);
        chk(rb == exp, req, rb, exp);
        chk(bad == 0, "R6 enables per phase (R4/R5 routing)", bad, 0);
    endtask

    task automatic t_short_write;
        logic [7:0] rb; int bad; int w0; logic [7:0] old;
        w0 = wr_cnt; old = mem[7'h31];
        run_frame(7'h31, 1'b1, 8'hE7, 12, rb, bad);
        chk(wr_cnt == w0, "R3 no strobe on short write", wr_cnt - w0, 0);
        chk(mem[7'h31] == old, "R3 register unchanged", mem[7'h31], old);
    endtask

    task automatic t_abort_then_write;
        logic [7:0] rb; int bad;
        run_frame(7'h7F, 1'b1, 8'hFF, 4, rb, bad);
        run_frame(7'h0A, 1'b1, 8'h3C, 16, rb, bad);
        chk(mem[7'h0A] == 8'h3C, "R7 frame after abort decoded", mem[7'h0A], 8'h3C);
    endtask

    task automatic t_long_write;
        logic [7:0] rb; int bad; int w0;
        w0 = wr_cnt;
        run_frame(7'h40, 1'b1, 8'h81, 18, rb, bad);
        chk(wr_cnt == w0 + 1, "R2 extra bits ignored", wr_cnt - w0, 1);
        chk(mem[7'h40] == 8'h81, "R2 data kept", mem[7'h40], 8'h81);
    endtask

    task automatic t_abort_read;
        logic [7:0] rb; int bad; logic [7:0] exp;
        run_frame(7'h23, 1'b0, 8'h00, 10, rb, bad);
        chk(!sio_oe && !so_oe, "R6 release on abort mid read", {sio_oe, so_oe}, 0);
        exp = mem[7'h05];
        run_frame(7'h05, 1'b0, 8'h00, 16, rb, bad);
        chk(rb == exp, "R7 read after aborted read", rb, exp);
    endtask

    initial begin
        idle(4);
        t_reset;
        rst_n = 1'b1;
        idle(4);
        t_reset;
        t_write(7'h23, 8'hC6);
        t_read(7'h23, "R4 shared-line read 23h");
        t_read(7'h05, "R4 shared-line read 05h");
        chk(clash == 0, "R4 no line contention", clash, 0);
        t_write(7'h14, 8'h01);
        t_read(7'h23, "R5 separate-line read 23h");
        t_read(7'h7F, "R5 separate-line read 7Fh");
        t_write(7'h14, 8'h00);
        t_short_write;
        t_abort_then_write;
        t_long_write;
        t_abort_read;
        chk(clash == 0, "R4 no line contention at end", clash, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog R1 actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule